// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor Core

This block is a compact processor that keeps code and data in one shared memory. Every instruction walks through a fixed run of register transfers between a program counter, a memory address register, a memory data register, an instruction register and an accumulator. Memory is never addressed directly from the program counter or the instruction. The address output always comes from the address register, and write data always comes from the data register.

The core drives a synchronous single-port memory through four signals: an address, write data, a one-cycle write strobe and read data. Read data is returned one clock after the address is presented. A small instruction set covers moving data in and out of the accumulator, arithmetic, bitwise logic, branches and stopping. After a stop instruction, a sticky flag reports that the core is idle.

Top module: `acc_core`

## Requirements
- R1: While `rst_n` is low, `halted` is 0, `mem_we` is 0 and `mem_addr` is 0. The reset is applied asynchronously. Its release passes through two clock edges before the core takes its first step.
- R2: An instruction word carries the opcode in bits 15:12 and a 12-bit address or target in bits 11:0. The opcodes are: 0 stop, 1 load, 2 store, 3 add, 4 subtract, 5 AND, 6 OR, 7 invert, 8 jump, 9 jump-if-zero.
- R3: Fetch takes four cycles: address register from program counter; memory wait, with the program counter incremented; data register from memory; instruction register from data register. Decode then takes one cycle. The program counter already points past the instruction before execution begins.
- R4: Load and add each spend 9 cycles in total. The operand is read through the address and data registers. Load places the word in the accumulator, and add places the wrapped 16-bit sum there.
- R5: Store takes 7 cycles in total. It raises `mem_we` for exactly one cycle, with `mem_addr` equal to the operand field and `mem_wdata` equal to the accumulator.
- R6: Subtract takes 9 cycles and yields the accumulator minus the memory word, modulo 2^16. For example, 5 - 7 gives 0xFFFE, and 0xFFFF + 1 gives 0.
- R7: AND and OR take 9 cycles each. They combine the accumulator bitwise with the memory word.
- R8: Invert takes 6 cycles. It complements every accumulator bit and ignores its operand field.
- R9: Jump takes 6 cycles and loads the program counter with the operand field.
- R10: Jump-if-zero takes 6 cycles. It loads the program counter with the operand only when the accumulator is zero; otherwise execution falls through.
- R11: Opcodes 10 to 15 take 5 cycles, change neither the accumulator nor memory, and continue with the next word.
- R12: A stop instruction sets `halted` on the fifth cycle after its fetch starts. From then on `halted` stays 1, `mem_we` stays 0 and `mem_addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| mem_addr | output | 12 | Memory address, driven from the address register |
| mem_wdata | output | 16 | Write data, driven from the data register |
| mem_we | output | 1 | Single-cycle write strobe |
| mem_rdata | input | 16 | Read data, valid one clock after the address |
| halted | output | 1 | Sticky stop indication |

## Verification
The bench aims at the edges of arithmetic wrap: a subtract that goes below zero and an add that overflows to zero. A core with a wrong width or carry would store a value that is off by one bit or one word. Jump-if-zero is run both with a nonzero and with a zero accumulator. Stores are placed on the skipped paths, so a branch taken on the wrong condition writes an unexpected word or misses an expected one. Undefined opcodes carry operand fields that point at live data, and the invert instruction carries a far-away operand; a decoder that treats either as a memory operation changes the stored result. Exact cycle totals to the stop flag expose a core that increments the program counter late, skips the memory wait state, or keeps fetching after the stop instruction.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OPC_HALT  = 4'd0;
  localparam logic [OP_W-1:0] OPC_LOAD  = 4'd1;
  localparam logic [OP_W-1:0] OPC_STORE = 4'd2;
  localparam logic [OP_W-1:0] OPC_ADD   = 4'd3;
  localparam logic [OP_W-1:0] OPC_SUB   = 4'd4;
  localparam logic [OP_W-1:0] OPC_AND   = 4'd5;
  localparam logic [OP_W-1:0] OPC_OR    = 4'd6;
  localparam logic [OP_W-1:0] OPC_NOT   = 4'd7;
  localparam logic [OP_W-1:0] OPC_JUMP  = 4'd8;
  localparam logic [OP_W-1:0] OPC_JZ    = 4'd9;

  typedef enum logic [3:0] {
    ST_FADDR,   // address register <- program counter
    ST_FWAIT,   // memory access cycle, program counter advances
    ST_FDATA,   // data register <- memory
    ST_FIR,     // instruction register <- data register
    ST_DEC,     // opcode dispatch
    ST_XADDR,   // address register <- operand (store also loads data register)
    ST_XWAIT,   // operand read wait
    ST_XDATA,   // data register <- memory
    ST_XALU,    // accumulator <- ALU
    ST_XWRITE,  // write strobe
    ST_XNOT,    // accumulator inverted
    ST_XBRANCH, // program counter <- target when taken
    ST_HALT
  } state_e;

  typedef struct packed {
    logic mar_we;
    logic mar_sel_pc;
    logic mdr_we;
    logic mdr_sel_acc;
    logic ir_we;
    logic pc_inc;
    logic pc_load;
    logic acc_we;
    logic halt_set;
    logic mem_we;
  } ctl_t;

endpackage

// File: rtl/acc_rst_sync.sv
module acc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      assign sync_d = 1'b1;
    end else begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_out_n = sync_q[STAGES-1];

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [OP_W-1:0] opc,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic [W-1:0]    y
);

  always_comb begin
    unique case (opc)
      OPC_LOAD: y = b;
      OPC_ADD:  y = a + b;
      OPC_SUB:  y = a - b;
      OPC_AND:  y = a & b;
      OPC_OR:   y = a | b;
      OPC_NOT:  y = ~a;
      default:  y = a;
    endcase
  end

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] opc,
  input  logic            acc_zero,
  output state_e          state,
  output ctl_t            ctl
);

  state_e state_q, state_d;
  logic   is_mem_read;

  assign is_mem_read = (opc == OPC_LOAD) || (opc == OPC_ADD) || (opc == OPC_SUB) ||
                       (opc == OPC_AND)  || (opc == OPC_OR);

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FADDR: state_d = ST_FWAIT;
      ST_FWAIT: state_d = ST_FDATA;
      ST_FDATA: state_d = ST_FIR;
      ST_FIR:   state_d = ST_DEC;
      ST_DEC: begin
        if (opc == OPC_HALT)                        state_d = ST_HALT;
        else if (is_mem_read || opc == OPC_STORE)   state_d = ST_XADDR;
        else if (opc == OPC_NOT)                    state_d = ST_XNOT;
        else if (opc == OPC_JUMP || opc == OPC_JZ)  state_d = ST_XBRANCH;
        else                                        state_d = ST_FADDR;
      end
      ST_XADDR:   state_d = (opc == OPC_STORE) ? ST_XWRITE : ST_XWAIT;
      ST_XWAIT:   state_d = ST_XDATA;
      ST_XDATA:   state_d = ST_XALU;
      ST_XALU:    state_d = ST_FADDR;
      ST_XWRITE:  state_d = ST_FADDR;
      ST_XNOT:    state_d = ST_FADDR;
      ST_XBRANCH: state_d = ST_FADDR;
      ST_HALT:    state_d = ST_HALT;
      default:    state_d = ST_FADDR;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FADDR;
    else        state_q <= state_d;
  end

  // per-state transfer enables
  always_comb begin
    ctl = '0;
    unique case (state_q)
      ST_FADDR: begin
        ctl.mar_we     = 1'b1;
        ctl.mar_sel_pc = 1'b1;
      end
      ST_FWAIT:  ctl.pc_inc = 1'b1;
      ST_FDATA:  ctl.mdr_we = 1'b1;
      ST_FIR:    ctl.ir_we  = 1'b1;
      ST_DEC:    ctl.halt_set = (opc == OPC_HALT);
      ST_XADDR: begin
        ctl.mar_we      = 1'b1;
        ctl.mdr_we      = (opc == OPC_STORE);
        ctl.mdr_sel_acc = (opc == OPC_STORE);
      end
      ST_XDATA:   ctl.mdr_we = 1'b1;
      ST_XALU:    ctl.acc_we = 1'b1;
      ST_XNOT:    ctl.acc_we = 1'b1;
      ST_XWRITE:  ctl.mem_we = 1'b1;
      ST_XBRANCH: ctl.pc_load = (opc == OPC_JUMP) || (opc == OPC_JZ && acc_zero);
      default:    ctl = '0;
    endcase
  end

  assign state = state_q;

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int SYNC_DEPTH = 2,
  localparam int ADDR_W    = DATA_W - OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted
);

  logic rst_core_n;

  logic [ADDR_W-1:0] pc_q,  pc_d;
  logic [ADDR_W-1:0] mar_q, mar_d;
  logic [DATA_W-1:0] mdr_q, mdr_d;
  logic [DATA_W-1:0] ir_q,  ir_d;
  logic [DATA_W-1:0] acc_q, acc_d;
  logic              halt_q, halt_d;

  logic [OP_W-1:0]   opc;
  logic [ADDR_W-1:0] operand;
  logic [DATA_W-1:0] alu_y;
  state_e            state;
  ctl_t              ctl;

  assign opc     = ir_q[DATA_W-1 -: OP_W];
  assign operand = ir_q[ADDR_W-1:0];

  acc_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst (
    .clk       (clk),
    .rst_in_n  (rst_n),
    .rst_out_n (rst_core_n)
  );

  acc_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .opc      (opc),
    .acc_zero (acc_q == '0),
    .state    (state),
    .ctl      (ctl)
  );

  acc_alu #(.W(DATA_W)) u_alu (
    .opc (opc),
    .a   (acc_q),
    .b   (mdr_q),
    .y   (alu_y)
  );

  // datapath next values
  always_comb begin
    pc_d   = pc_q;
    mar_d  = mar_q;
    mdr_d  = mdr_q;
    ir_d   = ir_q;
    acc_d  = acc_q;
    halt_d = halt_q;
    if (ctl.pc_inc)   pc_d   = pc_q + 1'b1;
    if (ctl.pc_load)  pc_d   = operand;
    if (ctl.mar_we)   mar_d  = ctl.mar_sel_pc ? pc_q : operand;
    if (ctl.mdr_we)   mdr_d  = ctl.mdr_sel_acc ? acc_q : mem_rdata;
    if (ctl.ir_we)    ir_d   = mdr_q;
    if (ctl.acc_we)   acc_d  = alu_y;
    if (ctl.halt_set) halt_d = 1'b1;
  end

  // datapath registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      pc_q   <= '0;
      mar_q  <= '0;
      mdr_q  <= '0;
      ir_q   <= '0;
      acc_q  <= '0;
      halt_q <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      mar_q  <= mar_d;
      mdr_q  <= mdr_d;
      ir_q   <= ir_d;
      acc_q  <= acc_d;
      halt_q <= halt_d;
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;
  assign mem_we    = ctl.mem_we;
  assign halted    = halt_q;

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_core_n,
  input state_e            state,
  input logic [ADDR_W-1:0] pc_q,
  input logic [ADDR_W-1:0] mar_q,
  input logic [DATA_W-1:0] mdr_q,
  input logic [DATA_W-1:0] ir_q,
  input logic [DATA_W-1:0] acc_q,
  input logic              halted,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata
);

  // R3: address register takes the program counter at fetch start
  p_mar_from_pc_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state == ST_FADDR) |=> (mar_q == $past(pc_q)));

  // R3: program counter steps during the fetch wait cycle
  p_pc_step_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state == ST_FWAIT) |=> (pc_q == ADDR_W'($past(pc_q) + 1)));

  // R3: instruction register is filled from the data register
  p_ir_from_mdr_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state == ST_FIR) |=> (ir_q == $past(mdr_q)));

  // R5: written word equals the accumulator
  p_wdata_is_acc_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    mem_we |-> (mem_wdata == acc_q));

  // R5: strobe lasts one cycle
  p_we_pulse_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    mem_we |=> !mem_we);

  // R12: stop flag is sticky
  p_halt_sticky_r12: assert property (@(posedge clk) disable iff (!rst_core_n)
    halted |=> halted);

  // R12: no writes once stopped
  p_halt_quiet_r12: assert property (@(posedge clk) disable iff (!rst_core_n)
    halted |-> !mem_we);

  // R12: address output frozen once stopped
  p_halt_addr_r12: assert property (@(posedge clk) disable iff (!rst_core_n)
    halted |=> $stable(mem_addr));

endmodule

bind acc_core acc_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .state      (state),
  .pc_q       (pc_q),
  .mar_q      (mar_q),
  .mdr_q      (mdr_q),
  .ir_q       (ir_q),
  .acc_q      (acc_q),
  .halted     (halted),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata)
);

// File: tb/acc_core_tb_top.sv
module acc_core_tb_top;

  localparam int DW = 16;
  localparam int AW = 12;
  localparam int SYNC_EDGES = 2;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we;
  logic [DW-1:0] mem_rdata;
  logic          halted;

  typedef struct {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    string         req;
  } store_t;

  store_t exp_q[$];
  logic [DW-1:0] mem [0:255];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  acc_core dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_rdata (mem_rdata),
    .halted    (halted)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural memory: registered read, one-cycle latency
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5", "unexpected store addr", {20'd0, mem_addr}, 32'hFFFF_FFFF);
      end else begin
        store_t e;
        e = exp_q.pop_front();
        chk(mem_addr == e.a, e.req, "store address", {20'd0, mem_addr}, {20'd0, e.a});
        chk(mem_wdata == e.d, e.req, "store data", {16'd0, mem_wdata}, {16'd0, e.d});
      end
    end
  end

  function automatic logic [DW-1:0] ins(input int op, input int arg);
    return {op[3:0], arg[11:0]};
  endfunction

  task automatic expect_store(input int a, input int d, input string req);
    store_t e;
    e.a = a[AW-1:0];
    e.d = d[DW-1:0];
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic clear_mem();
    exp_q.delete();
    for (int i = 0; i < 256; i++) mem[i] = '0;
  endtask

  task automatic hold_reset();
    rst_n = 1'b0;
    @(negedge clk);
    chk(halted == 1'b0, "R1", "halted in reset", {31'd0, halted}, 32'd0);
    chk(mem_we == 1'b0, "R1", "we in reset", {31'd0, mem_we}, 32'd0);
    chk(mem_addr == '0, "R1", "addr in reset", {20'd0, mem_addr}, 32'd0);
  endtask

  task automatic run_prog(input string req, input int core_cycles);
    int cnt;
    bit done;
    logic [AW-1:0] hold_addr;
    cnt = 0;
    done = 0;
    @(negedge clk);
    rst_n = 1'b1;
    while (!done && cnt < 3000) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      if (halted) done = 1;
    end
    chk(done, "R12", "halted reached", {31'd0, done}, 32'd1);
    chk(cnt == core_cycles + SYNC_EDGES, req, "cycles to halt", cnt, core_cycles + SYNC_EDGES);
    hold_addr = mem_addr;
    repeat (20) @(negedge clk);
    chk(halted == 1'b1, "R12", "halted sticky", {31'd0, halted}, 32'd1);
    chk(mem_addr == hold_addr, "R12", "addr held after halt", {20'd0, mem_addr}, {20'd0, hold_addr});
    chk(exp_q.size() == 0, req, "pending expected stores", exp_q.size(), 32'd0);
    exp_q.delete();
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);

    // R4 R5: load 15, add 7, store -> 22
    hold_reset(); clear_mem();
    mem[0] = ins(1, 'h40); mem[1] = ins(3, 'h41); mem[2] = ins(2, 'h50); mem[3] = ins(0, 0);
    mem['h40] = 16'd15; mem['h41] = 16'd7;
    expect_store('h50, 22, "R4");
    run_prog("R4", 9 + 9 + 7 + 5);
    chk(mem['h50] == 16'd22, "R5", "memory holds sum", {16'd0, mem['h50]}, 32'd22);

    // R6: subtract below zero, add overflow to zero
    hold_reset(); clear_mem();
    mem[0] = ins(1, 'h40); mem[1] = ins(4, 'h41); mem[2] = ins(2, 'h50);
    mem[3] = ins(1, 'h43); mem[4] = ins(3, 'h44); mem[5] = ins(2, 'h51); mem[6] = ins(0, 0);
    mem['h40] = 16'd5; mem['h41] = 16'd7; mem['h43] = 16'hFFFF; mem['h44] = 16'd1;
    mem['h51] = 16'h5555;
    expect_store('h50, 'hFFFE, "R6");
    expect_store('h51, 'h0000, "R6");
    run_prog("R6", 9 + 9 + 7 + 9 + 9 + 7 + 5);

    // R7 R8: AND, OR, invert with a far operand
    hold_reset(); clear_mem();
    mem[0] = ins(1, 'h40); mem[1] = ins(5, 'h41); mem[2] = ins(2, 'h50);
    mem[3] = ins(6, 'h42); mem[4] = ins(2, 'h51); mem[5] = ins(7, 'h7FF);
    mem[6] = ins(2, 'h52); mem[7] = ins(0, 0);
    mem['h40] = 16'hA5C3; mem['h41] = 16'h0FF0; mem['h42] = 16'hF00F;
    expect_store('h50, 'h05C0, "R7");
    expect_store('h51, 'hF5CF, "R7");
    expect_store('h52, 'h0A30, "R8");
    run_prog("R8", 9 + 9 + 7 + 9 + 7 + 6 + 7 + 5);

    // R9 R10: jump and jump-if-zero in both outcomes
    hold_reset(); clear_mem();
    mem[0] = ins(1, 'h40); mem[1] = ins(9, 4); mem[2] = ins(2, 'h50); mem[3] = ins(8, 6);
    mem[4] = ins(2, 'h51); mem[5] = ins(0, 0); mem[6] = ins(4, 'h40); mem[7] = ins(9, 9);
    mem[8] = ins(2, 'h52); mem[9] = ins(2, 'h53); mem[10] = ins(0, 0);
    mem['h40] = 16'd3; mem['h53] = 16'h7777;
    expect_store('h50, 3, "R10");
    expect_store('h53, 0, "R9");
    run_prog("R10", 9 + 6 + 7 + 6 + 9 + 6 + 7 + 5);

    // R11 R2: undefined opcodes are no-ops
    hold_reset(); clear_mem();
    mem[0] = ins(1, 'h40); mem[1] = ins(10, 'h041); mem[2] = ins(15, 'h050);
    mem[3] = ins(2, 'h50); mem[4] = ins(0, 0);
    mem['h40] = 16'h1234; mem['h41] = 16'h9999;
    expect_store('h50, 'h1234, "R11");
    run_prog("R11", 9 + 5 + 5 + 7 + 5);

    // R12 R3: stop at address 0, store after it never runs
    hold_reset(); clear_mem();
    mem[0] = ins(0, 0); mem[1] = ins(2, 'h50);
    mem['h50] = 16'hABCD;
    run_prog("R3", 5);
    chk(mem['h50] == 16'hABCD, "R12", "no write after halt", {16'd0, mem['h50]}, 32'hABCD);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule